// File: doc/BRIEF.md
# Non-Volatile Array Program/Erase Controller

This block guards a word-addressed non-volatile storage array that is split into a main area of equal-sized pages and a small user-configuration area. A mode register chooses whether the array is locked, open for word programming, or open for erasure. Bus writes into the array and erase commands only act when the matching mode is selected. An erase clears storage to all ones, at three sizes: one page, the whole main area, or the whole user area. A status word reports that the controller is always ready. The storage is a behavioural memory inside the block. It comes up erased after reset, and every operation finishes in the clock edge that accepts it.

The mode register is a four-state machine. Its states are `MODE_LOCKED` (code 0), `MODE_PROGRAM` (code 1), `MODE_ERASE` (code 2) and `MODE_SPARE` (code 3), and `MODE_SPARE` acts like `MODE_LOCKED`. There is exactly one transition rule. A bus write to the mode register moves the machine from any state to the state whose code equals the two low bits of the written word. Without such a write the state holds. Reset enters `MODE_LOCKED`.

The bus has one write strobe and a combinational read path. `bus_space` selects the area: 0 is main, 1 is user, 2 is control, and 3 is unmapped and reads 0. Control word offsets are 0 status, 1 mode, 2 and 3 the two page-erase registers, 4 whole-main erase, and 5 user erase. Other control offsets read 0.

Top module: `nvm_ctrl`

## Requirements
- R1: Reading control offset 0 returns 1 in bit 0 and 0 in every other bit, in every mode.
- R2: The mode register at control offset 1 resets to 0. A write stores the two low bits of the data, and the register reads back those bits (values 0, 1, 2 and 3 all read back unchanged, and higher bits read 0).
- R3: After reset every word of the main area and of the user area reads 0xFFFFFFFF.
- R4: In mode 1, a write to an in-range word of the main area (space 0) or of the user area (space 1) can be read back with the new value once the accepting clock edge has passed.
- R5: Array writes in mode 0, 2 or 3 leave the addressed word unchanged.
- R6: In mode 2, writing a main-area word address to control offset 2 or to offset 3 sets all words of the page holding that address to 0xFFFFFFFF. The address does not need to be page-aligned, and the neighbouring pages keep their contents.
- R7: In mode 2, writing exactly 1 to control offset 4 sets every main-area word to 0xFFFFFFFF and leaves the user area as it was. Any other value has no effect.
- R8: In mode 2, writing exactly 1 to control offset 5 sets every user-area word to 0xFFFFFFFF and leaves the main area as it was.
- R9: Erase commands written in modes 0, 1 or 3 have no effect.
- R10: A page-erase address equal to or above the number of main-area words is ignored, even in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_space | input | 2 | Area select: 0 main, 1 user, 2 control |
| bus_addr | input | ADDR_W (16) | Word address inside the selected area |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_space`/`bus_addr` |

## Verification
The bench sends each kind of write in a mode that should block it, including mode 3. A design that treats any non-zero mode as permission would overwrite a word or clear a page during these writes. Page erase is run through both command registers and with an address that is not page-aligned, and the words on both sides of the page are checked. An off-by-one in the page index, or a decode of only one of the two registers, would leave stale words or clear the wrong page. The erase commands are also given an out-of-range address and a value other than 1, to catch designs that do not qualify these commands. Whole-area erases are checked word by word, and the other area is checked as well, to catch a design that also clears that area.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        MODE_LOCKED  = 2'd0,
        MODE_PROGRAM = 2'd1,
        MODE_ERASE   = 2'd2,
        MODE_SPARE   = 2'd3
    } nvm_mode_e;

    localparam logic [1:0] SPACE_MAIN = 2'd0;
    localparam logic [1:0] SPACE_USER = 2'd1;
    localparam logic [1:0] SPACE_CTRL = 2'd2;

    localparam int OFS_STATUS  = 0;
    localparam int OFS_MODE    = 1;
    localparam int OFS_PAGE_A  = 2;
    localparam int OFS_PAGE_B  = 3;
    localparam int OFS_ALL     = 4;
    localparam int OFS_USER    = 5;

endpackage

// File: rtl/nvm_mode_fsm.sv
module nvm_mode_fsm
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_val,
    output nvm_mode_e  mode_q,
    output logic       prog_ok,
    output logic       erase_ok
);

    nvm_mode_e state_q;
    nvm_mode_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_LOCKED;
        else        state_q <= state_d;
    end

    // transition: a mode-register write jumps to the written code
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case (cfg_val)
                2'd0: state_d = MODE_LOCKED;
                2'd1: state_d = MODE_PROGRAM;
                2'd2: state_d = MODE_ERASE;
                2'd3: state_d = MODE_SPARE;
            endcase
        end
    end

    // outputs decoded from the current state
    always_comb begin
        prog_ok  = 1'b0;
        erase_ok = 1'b0;
        unique case (state_q)
            MODE_LOCKED:  ;
            MODE_PROGRAM: prog_ok  = 1'b1;
            MODE_ERASE:   erase_ok = 1'b1;
            MODE_SPARE:   ;
        endcase
    end

    assign mode_q = state_q;

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (2'(state_q) == $past(cfg_val)));  // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(state_q));  // R2

endmodule

// File: rtl/nvm_cmd_dec.sv
module nvm_cmd_dec
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int PAGES      = 256,
    parameter int PAGE_WORDS = 4,
    parameter int USER_WORDS = 8,
    localparam int MAIN_WORDS = PAGES * PAGE_WORDS,
    localparam int MAIN_AW    = $clog2(MAIN_WORDS),
    localparam int PW_BITS    = $clog2(PAGE_WORDS),
    localparam int PG_BITS    = MAIN_AW - PW_BITS,
    localparam int USER_AW    = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1
) (
    input  logic               bus_wr,
    input  logic [1:0]         bus_space,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               prog_ok,
    input  logic               erase_ok,
    output logic               main_hit,
    output logic               user_hit,
    output logic               cfg_we,
    output logic               main_we,
    output logic               user_we,
    output logic               page_erase,
    output logic [PG_BITS-1:0] page_idx,
    output logic               all_erase,
    output logic               user_erase
);

    logic ctrl_wr;
    logic page_in_range;
    logic is_one;

    assign main_hit      = (bus_addr < ADDR_W'(MAIN_WORDS));
    assign user_hit      = (bus_addr < ADDR_W'(USER_WORDS));
    assign ctrl_wr       = bus_wr && (bus_space == SPACE_CTRL);
    assign page_in_range = (bus_wdata < DATA_W'(MAIN_WORDS));
    assign is_one        = (bus_wdata == DATA_W'(1));

    assign cfg_we     = ctrl_wr && (bus_addr == ADDR_W'(OFS_MODE));
    assign main_we    = bus_wr && (bus_space == SPACE_MAIN) && main_hit && prog_ok;
    assign user_we    = bus_wr && (bus_space == SPACE_USER) && user_hit && prog_ok;
    assign page_erase = ctrl_wr && erase_ok && page_in_range &&
                        ((bus_addr == ADDR_W'(OFS_PAGE_A)) ||
                         (bus_addr == ADDR_W'(OFS_PAGE_B)));
    assign all_erase  = ctrl_wr && erase_ok && is_one &&
                        (bus_addr == ADDR_W'(OFS_ALL));
    assign user_erase = ctrl_wr && erase_ok && is_one &&
                        (bus_addr == ADDR_W'(OFS_USER));
    assign page_idx   = bus_wdata[MAIN_AW-1:PW_BITS];

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int DATA_W     = 32,
    parameter int PAGES      = 256,
    parameter int PAGE_WORDS = 4,
    parameter int USER_WORDS = 8,
    localparam int MAIN_WORDS = PAGES * PAGE_WORDS,
    localparam int MAIN_AW    = $clog2(MAIN_WORDS),
    localparam int PW_BITS    = $clog2(PAGE_WORDS),
    localparam int PG_BITS    = MAIN_AW - PW_BITS,
    localparam int USER_AW    = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               main_we,
    input  logic [MAIN_AW-1:0] main_idx,
    input  logic               user_we,
    input  logic [USER_AW-1:0] user_idx,
    input  logic               page_erase,
    input  logic [PG_BITS-1:0] page_idx,
    input  logic               all_erase,
    input  logic               user_erase,
    output logic [DATA_W-1:0]  main_q,
    output logic [DATA_W-1:0]  user_q
);

    logic [DATA_W-1:0] main_mem [MAIN_WORDS];
    logic [DATA_W-1:0] user_mem [USER_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_WORDS; i++) main_mem[i] <= '1;
        end else if (all_erase) begin
            for (int i = 0; i < MAIN_WORDS; i++) main_mem[i] <= '1;
        end else if (page_erase) begin
            for (int w = 0; w < PAGE_WORDS; w++)
                main_mem[{page_idx, PW_BITS'(w)}] <= '1;
        end else if (main_we) begin
            main_mem[main_idx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < USER_WORDS; i++) user_mem[i] <= '1;
        end else if (user_erase) begin
            for (int i = 0; i < USER_WORDS; i++) user_mem[i] <= '1;
        end else if (user_we && (int'(user_idx) < USER_WORDS)) begin
            user_mem[user_idx] <= wdata;
        end
    end

    assign main_q = main_mem[main_idx];
    assign user_q = (int'(user_idx) < USER_WORDS) ? user_mem[user_idx] : '0;

    AST_PAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        page_erase |=> (main_mem[{$past(page_idx), PW_BITS'(0)}] == '1));  // R6
    AST_MAIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        all_erase |=> (main_mem[MAIN_WORDS-1] == '1));  // R7
    AST_USER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        user_erase |=> (user_mem[0] == '1));  // R8

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int PAGES      = 256,
    parameter int PAGE_WORDS = 4,
    parameter int USER_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_space,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int MAIN_WORDS = PAGES * PAGE_WORDS;
    localparam int MAIN_AW    = $clog2(MAIN_WORDS);
    localparam int PW_BITS    = $clog2(PAGE_WORDS);
    localparam int PG_BITS    = MAIN_AW - PW_BITS;
    localparam int USER_AW    = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1;

    nvm_mode_e          mode_q;
    logic               prog_ok, erase_ok;
    logic               main_hit, user_hit;
    logic               cfg_we, main_we, user_we;
    logic               page_erase, all_erase, user_erase;
    logic [PG_BITS-1:0] page_idx;
    logic [DATA_W-1:0]  main_q, user_q;

    nvm_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_val  (bus_wdata[1:0]),
        .mode_q   (mode_q),
        .prog_ok  (prog_ok),
        .erase_ok (erase_ok)
    );

    nvm_cmd_dec #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGES(PAGES),
        .PAGE_WORDS(PAGE_WORDS), .USER_WORDS(USER_WORDS)
    ) u_dec (
        .bus_wr     (bus_wr),
        .bus_space  (bus_space),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .prog_ok    (prog_ok),
        .erase_ok   (erase_ok),
        .main_hit   (main_hit),
        .user_hit   (user_hit),
        .cfg_we     (cfg_we),
        .main_we    (main_we),
        .user_we    (user_we),
        .page_erase (page_erase),
        .page_idx   (page_idx),
        .all_erase  (all_erase),
        .user_erase (user_erase)
    );

    nvm_store #(
        .DATA_W(DATA_W), .PAGES(PAGES),
        .PAGE_WORDS(PAGE_WORDS), .USER_WORDS(USER_WORDS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata      (bus_wdata),
        .main_we    (main_we),
        .main_idx   (bus_addr[MAIN_AW-1:0]),
        .user_we    (user_we),
        .user_idx   (bus_addr[USER_AW-1:0]),
        .page_erase (page_erase),
        .page_idx   (page_idx),
        .all_erase  (all_erase),
        .user_erase (user_erase),
        .main_q     (main_q),
        .user_q     (user_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_space)
            SPACE_MAIN: if (main_hit) bus_rdata = main_q;
            SPACE_USER: if (user_hit) bus_rdata = user_q;
            SPACE_CTRL: begin
                if (bus_addr == ADDR_W'(OFS_STATUS)) bus_rdata = DATA_W'(1);
                else if (bus_addr == ADDR_W'(OFS_MODE)) bus_rdata = DATA_W'(mode_q);
            end
            default: bus_rdata = '0;
        endcase
    end

    AST_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_space == SPACE_CTRL) && (bus_addr == ADDR_W'(OFS_STATUS)))
            |-> (bus_rdata == DATA_W'(1)));  // R1
    AST_PROG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (main_we || user_we) |-> (mode_q == MODE_PROGRAM));  // R5
    AST_ERASE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (page_erase || all_erase || user_erase) |-> (mode_q == MODE_ERASE));  // R9

endmodule

// File: tb/nvm_ctrl_test.sv
`timescale 1ns/1ps
module nvm_ctrl_test;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MAIN_WORDS = 1024;
    localparam int USER_WORDS = 8;
    localparam logic [DW-1:0] ONES = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_space = 2'd0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nvm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sp, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_space = sp; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sp, input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_space = sp; bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic expect_word(input string req, input logic [1:0] sp, input int a,
                               input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(sp, a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        expect_word("R1 status after reset", 2'd2, 0, 32'h1);
        expect_word("R2 mode after reset", 2'd2, 1, 32'h0);
        expect_word("R3 main first", 2'd0, 0, ONES);
        expect_word("R3 main last", 2'd0, MAIN_WORDS - 1, ONES);
        expect_word("R3 user last", 2'd1, USER_WORDS - 1, ONES);
    endtask

    task automatic t_mode();
        wr(2'd2, 1, 32'h3);
        expect_word("R2 mode 3", 2'd2, 1, 32'h3);
        wr(2'd2, 1, 32'hFFFF_FF06);
        expect_word("R2 high bits dropped", 2'd2, 1, 32'h2);
        expect_word("R1 status in erase mode", 2'd2, 0, 32'h1);
        wr(2'd2, 1, 32'h0);
        expect_word("R2 mode 0", 2'd2, 1, 32'h0);
    endtask

    task automatic t_blocked_writes();
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            wr(2'd2, 1, DW'(m));
            wr(2'd0, 5, 32'h1234_5678);
            wr(2'd1, 2, 32'h8765_4321);
            expect_word("R5 main write blocked", 2'd0, 5, ONES);
            expect_word("R5 user write blocked", 2'd1, 2, ONES);
        end
    endtask

    task automatic t_program();
        wr(2'd2, 1, 32'h1);
        for (int i = 0; i < 12; i++) wr(2'd0, i, 32'hA000_0000 + DW'(i));
        for (int i = 0; i < 12; i++)
            expect_word("R4 main program", 2'd0, i, 32'hA000_0000 + DW'(i));
        wr(2'd0, MAIN_WORDS - 1, 32'hC0FF_EE00);
        expect_word("R4 main last word", 2'd0, MAIN_WORDS - 1, 32'hC0FF_EE00);
        for (int i = 0; i < USER_WORDS; i++) wr(2'd1, i, 32'hB000_0000 + DW'(i));
        for (int i = 0; i < USER_WORDS; i++)
            expect_word("R4 user program", 2'd1, i, 32'hB000_0000 + DW'(i));
    endtask

    task automatic t_erase_blocked();
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            wr(2'd2, 1, DW'(m));
            wr(2'd2, 2, 32'h0);
            wr(2'd2, 3, 32'h4);
            wr(2'd2, 4, 32'h1);
            wr(2'd2, 5, 32'h1);
            expect_word("R9 page erase blocked", 2'd0, 0, 32'hA000_0000);
            expect_word("R9 page B erase blocked", 2'd0, 4, 32'hA000_0004);
            expect_word("R9 main erase blocked", 2'd0, MAIN_WORDS - 1, 32'hC0FF_EE00);
            expect_word("R9 user erase blocked", 2'd1, 0, 32'hB000_0000);
        end
    endtask

    task automatic t_page_erase();
        wr(2'd2, 1, 32'h2);
        wr(2'd2, 2, 32'h4);
        expect_word("R6 below page kept", 2'd0, 3, 32'hA000_0003);
        for (int i = 4; i < 8; i++) expect_word("R6 page A cleared", 2'd0, i, ONES);
        expect_word("R6 above page kept", 2'd0, 8, 32'hA000_0008);
        wr(2'd2, 3, 32'h9);
        for (int i = 8; i < 12; i++) expect_word("R6 page B unaligned", 2'd0, i, ONES);
        expect_word("R6 first page kept", 2'd0, 0, 32'hA000_0000);
    endtask

    task automatic t_range();
        wr(2'd2, 2, DW'(MAIN_WORDS));
        wr(2'd2, 3, 32'hFFFF_FFFC);
        expect_word("R10 out-of-range ignored", 2'd0, MAIN_WORDS - 1, 32'hC0FF_EE00);
        expect_word("R10 page zero kept", 2'd0, 0, 32'hA000_0000);
    endtask

    task automatic t_erase_all();
        wr(2'd2, 4, 32'h2);
        expect_word("R7 value 2 ignored", 2'd0, 0, 32'hA000_0000);
        wr(2'd2, 4, 32'h1);
        for (int i = 0; i < MAIN_WORDS; i++) expect_word("R7 main cleared", 2'd0, i, ONES);
        expect_word("R7 user kept", 2'd1, 3, 32'hB000_0003);
    endtask

    task automatic t_user_erase();
        wr(2'd2, 1, 32'h1);
        wr(2'd0, 3, 32'h0000_0055);
        wr(2'd1, 5, 32'h0000_00AA);
        expect_word("R8 user writable", 2'd1, 5, 32'h0000_00AA);
        wr(2'd2, 1, 32'h2);
        wr(2'd2, 5, 32'h1);
        for (int i = 0; i < USER_WORDS; i++) expect_word("R8 user cleared", 2'd1, i, ONES);
        expect_word("R8 main kept", 2'd0, 3, 32'h0000_0055);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode();
        t_blocked_writes();
        t_program();
        t_erase_blocked();
        t_page_erase();
        t_range();
        t_erase_all();
        t_user_erase();
        report();
    end

endmodule